// File: doc/BRIEF.md
# DMA Channel Issue Scheduler

This block decides which DMA channel may issue its next bus transfer. Each of the N channels presents an enable, a request line and a priority-class bit. Each cycle the scheduler grants at most one channel, shown as a registered one-hot vector together with a valid strobe.

Scheduling runs in rounds. In the first part of a round, every enabled, requesting channel of the urgent class is granted once, in rotating order. The round then grants a single channel of the normal class and starts again with the urgent class. The class bit only sets the issue order. The block has no bus-priority output, so the class bit cannot change what the interconnect sees.

A normal-class channel loses no throughput when the urgent class is idle. In that case the normal slot is offered on every cycle.

Top module: `dma_issue_sched`

## Requirements
- R1: During and after reset `grant` is all zero and `grant_valid` is 0. Both rotation pointers start at channel 0, so the first grant of each class goes to the lowest-numbered eligible channel of that class.
- R2: `grant` is zero when `grant_valid` is 0 and one-hot when it is 1. The grant for the inputs present before a rising edge appears after that edge, which is one cycle of latency. Only a channel that was requesting can be granted.
- R3: Within a round, each enabled, requesting channel with `chan_hi`=1 is granted once before any channel with `chan_hi`=0 is granted.
- R4: After the urgent pass, exactly one normal-class channel is granted. Then a new round begins with the urgent class.
- R5: If no urgent channel is still eligible in the round, the normal slot is used in that same cycle. A lone normal-class requester is therefore granted on every cycle.
- R6: If no normal-class channel is eligible when the urgent pass ends, the round closes with no grant in that cycle's decision. The next round serves the urgent channels again.
- R7: A channel with `chan_en`=0 is never granted, whatever its request.
- R8: Within each class, the search starts at the channel after the last channel granted in that class and wraps from N-1 to 0.
- R9: With no enabled requester, `grant_valid` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_en | input | N | Channel enable, one bit per channel |
| chan_req | input | N | Transfer request, one bit per channel |
| chan_hi | input | N | 1 = urgent class, 0 = normal class |
| grant | output | N | One-hot issue grant, registered |
| grant_valid | output | 1 | Qualifies `grant` |

## Verification
Every decision is due exactly one rising edge after the inputs it is based on. The driver applies inputs at a falling edge and, at the same moment, pushes the expected grant from a round-based reference model. The monitor pops that item 2 ns after the next rising edge and compares it, so each check lines up with the single register stage. The reset state is checked directly before any stimulus. Patterns cover both classes fully loaded, a normal class running alone, an urgent class running alone, disabled channels and an idle bus.

// File: rtl/dma_issue_sched.sv
module dma_issue_sched #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] chan_en,
  input  logic [N-1:0] chan_req,
  input  logic [N-1:0] chan_hi,
  output logic [N-1:0] grant,
  output logic         grant_valid
);

  logic [N-1:0] hi_done;
  logic [W-1:0] hi_ptr, lo_ptr;
  logic [N-1:0] hi_cand, lo_cand;
  logic [W:0]   hi_pick, lo_pick;

  function automatic logic [W:0] rr_pick(input logic [N-1:0] m, input logic [W-1:0] s);
    logic [W:0] r;
    r = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(s) + k) % N;
      if (m[j]) r = {1'b1, W'(j)};
    end
    return r;
  endfunction

  function automatic logic [W-1:0] nxt(input logic [W-1:0] i);
    return (int'(i) == N - 1) ? '0 : i + 1'b1;
  endfunction

  assign hi_cand = chan_req & chan_en & chan_hi & ~hi_done;
  assign lo_cand = chan_req & chan_en & ~chan_hi;
  assign hi_pick = rr_pick(hi_cand, hi_ptr);
  assign lo_pick = rr_pick(lo_cand, lo_ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
      hi_done     <= '0;
      hi_ptr      <= '0;
      lo_ptr      <= '0;
    end else begin
      grant       <= '0;
      grant_valid <= 1'b0;
      if (hi_pick[W]) begin
        grant                 <= N'(1) << hi_pick[W-1:0];
        grant_valid           <= 1'b1;
        hi_done[hi_pick[W-1:0]] <= 1'b1;
        hi_ptr                <= nxt(hi_pick[W-1:0]);
      end else begin
        hi_done <= '0;
        if (lo_pick[W]) begin
          grant       <= N'(1) << lo_pick[W-1:0];
          grant_valid <= 1'b1;
          lo_ptr      <= nxt(lo_pick[W-1:0]);
        end
      end
    end
  end

endmodule

module dma_issue_sched_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] chan_en,
  input logic [N-1:0] chan_req,
  input logic [N-1:0] grant,
  input logic         grant_valid
);

  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $onehot(grant));

  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant == '0));

  p_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant & ~$past(chan_req)) == '0));

  p_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((grant & ~$past(chan_en)) == '0));

  p_noelig_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((chan_req & chan_en) == '0) |=> !grant_valid);

endmodule

bind dma_issue_sched dma_issue_sched_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_req(chan_req),
  .grant(grant), .grant_valid(grant_valid)
);

// File: tb/dma_issue_sched_tb.sv
module dma_issue_sched_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] chan_en = '0, chan_req = '0, chan_hi = '0;
  logic [N-1:0] grant;
  logic         grant_valid;

  typedef struct {
    logic [N-1:0] g;
    logic         v;
    string        tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int checks = 0, fails = 0;
  logic [N-1:0] m_done = '0;
  int m_hp = 0, m_lp = 0;

  always #4 clk = ~clk;

  dma_issue_sched #(.N(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .chan_req(chan_req),
    .chan_hi(chan_hi), .grant(grant), .grant_valid(grant_valid)
  );

  task automatic drive(input logic [N-1:0] en, req, hi, input string tag);
    exp_t e;
    int hit;
    @(negedge clk);
    chan_en = en; chan_req = req; chan_hi = hi;
    e.g = '0; e.v = 1'b0; e.tag = tag; hit = -1;
    for (int k = 0; k < N; k++) begin
      int j;
      j = (m_hp + k) % N;
      if (hit < 0 && req[j] && en[j] && hi[j] && !m_done[j]) hit = j;
    end
    if (hit >= 0) begin
      e.g[hit] = 1'b1; e.v = 1'b1; m_done[hit] = 1'b1; m_hp = (hit + 1) % N;
    end else begin
      m_done = '0;
      for (int k = 0; k < N; k++) begin
        int j;
        j = (m_lp + k) % N;
        if (hit < 0 && req[j] && en[j] && !hi[j]) hit = j;
      end
      if (hit >= 0) begin
        e.g[hit] = 1'b1; e.v = 1'b1; m_lp = (hit + 1) % N;
      end
    end
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      if (grant !== cur.g || grant_valid !== cur.v) begin
        fails++;
        $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%b",
                 cur.tag, grant, grant_valid, cur.g, cur.v);
      end
    end
  end

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (grant !== '0 || grant_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: grant=%b valid=%b expected grant=0000 valid=0", grant, grant_valid);
    end
    rst_n = 1'b1;
    // R1 R3 R4 R8: both classes loaded; urgent = ch0, ch1
    for (int i = 0; i < 9; i++) drive(4'b1111, 4'b1111, 4'b0011, "R1 R3 R4 R8 mixed");
    // R5: only the normal class requests
    for (int i = 0; i < 6; i++) drive(4'b1111, 4'b1100, 4'b0011, "R5 normal alone");
    // R6: only the urgent class requests
    for (int i = 0; i < 6; i++) drive(4'b1111, 4'b0011, 4'b0011, "R6 urgent alone");
    // R7: ch1 and ch3 disabled
    for (int i = 0; i < 6; i++) drive(4'b0101, 4'b1111, 4'b0011, "R7 disabled");
    // R2 R8: alternate classes with shifting requests
    for (int i = 0; i < 8; i++) drive(4'b1111, 4'(4'b1011 >> (i % 3)), 4'b1010, "R2 R8 shifting");
    // R9: idle and requests only from disabled channels
    for (int i = 0; i < 3; i++) drive(4'b1111, 4'b0000, 4'b0011, "R9 idle");
    for (int i = 0; i < 3; i++) drive(4'b0000, 4'b1111, 4'b0011, "R9 R7 all off");
    @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule